// File: doc/BRIEF.md
# Additive-Reload Periodic Tick Timer

This block is an 8-bit up-counter. A fixed divide-by-4 prescaler drives it from the instruction clock. It keeps running with no help from software. Each wrap of the count from its top value to zero sets a sticky interrupt flag. The flag stays high until software pulses the clear input.

Software can shorten the period through a write port. The write does not load a fresh value into the counter. It adds an amount to whatever the live count holds at that moment. Each write also costs the counter its next two prescaled increments, and the added amount has to cover that loss. Because the correction is relative, the tick spacing does not depend on how long software took to respond to the interrupt. An add of 8 gains 8 counts and loses 2 increments, so the period drops from 256 to 250 prescaled counts. At a 1 µs instruction clock that is a 1 ms tick.

Top module: `addreload_timer`

## Requirements
- R1: While reset is asserted, the count reads 0 and the interrupt output is low.
- R2: With no write, the count rises by exactly one on every fourth clock edge after reset release, at edges 4, 8, 12 and so on, and it holds on all other edges.
- R3: With no write, the count wraps from 255 to 0 every 1024 clock cycles. The first wrap after reset release falls on edge 1024.
- R4: The interrupt output stays high after it is set until a clock edge sees the clear input high. On that edge it goes low, unless a new overflow occurs on the same edge, in which case it stays high.
- R5: A clock edge that sees the write strobe replaces the count with the old count plus the add value, modulo 256. Any increment due on that same edge is dropped.
- R6: A write discards exactly two prescaled increments in total: the increment due on the write edge, if there is one, counts as the first of the two. The prescaler phase itself is never reset.
- R7: An add whose unwrapped sum exceeds 255 sets the interrupt flag on the write edge.
- R8: If software adds 8 at any point within a period, after the wrap that starts it and before the count reaches 248, the next wrap follows the previous one by exactly 1000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Add strobe, one cycle per correction |
| addVal | input | 8 | Amount added to the live count |
| irqClr | input | 1 | Clears the sticky interrupt flag |
| count | output | 8 | Live counter value |
| irq | output | 1 | Sticky overflow interrupt flag |

## Verification
The bench issues the add of 8 after wrap-to-write delays that vary at random, so some writes land exactly on an increment edge. A design that reset the prescaler phase on a write, or that lost a third increment at such an edge, would make the 1000-cycle period drift with the delay. Directed adds near the top of the range check wrap-around during the add. A design that ignored the carry out of the add would miss that interrupt. A long random stretch of writes, clears and add values is compared cycle by cycle against a model built from the requirements. That comparison exposes a skip window of the wrong length and a lost or unsticky flag.

// File: rtl/addreload_pkg.sv
package addreload_pkg;
  // Strobes from the sequencing logic to the count register
  typedef struct packed {
    logic addEn;   // apply the software correction this edge
    logic incEn;   // apply one prescaled increment this edge
  } ctlStrobe_t;
endpackage

// File: rtl/arl_ctrl.sv
module arl_ctrl
  import addreload_pkg::*;
#(
  parameter int PRE_W = 2,   // prescaler divides by 2**PRE_W
  parameter int SKIP  = 2    // increments swallowed after each write (>=1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  output ctlStrobe_t strobe
);
  localparam int SKIP_W = $clog2(SKIP + 1);

  logic              preTick;
  logic [SKIP_W-1:0] skipLeft;

  generate
    if (PRE_W == 0) begin : g_noPre
      assign preTick = 1'b1;
    end else begin : g_pre
      logic [PRE_W-1:0] preCnt;
      // Free-running phase: writes never disturb it
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) preCnt <= '0;
        else       preCnt <= preCnt + 1'b1;
      end
      assign preTick = &preCnt;
    end
  endgenerate

  // A write arms the skip window. A tick that lands on the write edge uses up one slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skipLeft <= '0;
    end else if (wrEn) begin
      skipLeft <= preTick ? SKIP_W'(SKIP - 1) : SKIP_W'(SKIP);
    end else if (preTick && skipLeft != '0) begin
      skipLeft <= skipLeft - 1'b1;
    end
  end

  always_comb begin
    strobe.addEn = wrEn;
    strobe.incEn = preTick && !wrEn && (skipLeft == '0);
  end
endmodule

// File: rtl/arl_datapath.sv
module arl_datapath
  import addreload_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [CNT_W-1:0] addVal,
  input  logic             irqClr,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] nextCount;
  logic             wrapNow;

  always_comb begin
    sum       = {1'b0, count} + {1'b0, addVal};
    nextCount = count;
    wrapNow   = 1'b0;
    if (strobe.addEn) begin
      nextCount = sum[CNT_W-1:0];
      wrapNow   = sum[CNT_W];
    end else if (strobe.incEn) begin
      nextCount = count + 1'b1;
      wrapNow   = &count;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      count <= nextCount;
      if (wrapNow)     irq <= 1'b1;   // set beats clear
      else if (irqClr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/addreload_timer.sv
module addreload_timer
  import addreload_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 2,
  parameter int SKIP  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] addVal,
  input  logic             irqClr,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  ctlStrobe_t strobe;

  arl_ctrl #(.PRE_W(PRE_W), .SKIP(SKIP)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .strobe(strobe)
  );

  arl_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addVal(addVal),
    .irqClr(irqClr), .count(count), .irq(irq)
  );
endmodule

// File: rtl/arl_chk.sv
module arl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [CNT_W-1:0] addVal,
  input logic             irqClr,
  input logic [CNT_W-1:0] count,
  input logic             irq
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1)));

  assert_add_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> count == CNT_W'($past(count) + $past(addVal)));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClr) |=> irq);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && !wrEn && count != '1) |=> !irq);

  assert_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(wrEn) || $past(count) == '1));
endmodule

bind addreload_timer arl_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addVal(addVal),
  .irqClr(irqClr), .count(count), .irq(irq)
);

// File: tb/sim_addreload_timer.sv
module sim_addreload_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] addVal = '0;
  logic       irqClr = 1'b0;
  logic [7:0] count;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmpOn = 1'b0;
  string curTag = "R2";

  // Reference state kept from the requirements
  logic [1:0] mPre;
  logic [7:0] mCount;
  logic [1:0] mSkip;
  logic       mFlag;

  addreload_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addVal(addVal),
    .irqClr(irqClr), .count(count), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [8:0] addSum(input logic [7:0] a, input logic [7:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPre <= '0; mCount <= '0; mSkip <= '0; mFlag <= 1'b0; cyc <= 0;
    end else begin
      logic tick, ovf;
      logic [8:0] s;
      tick = (mPre == 2'd3);
      ovf  = 1'b0;
      cyc  <= cyc + 1;
      mPre <= mPre + 2'd1;
      if (wrEn) begin
        s = addSum(mCount, addVal);
        mCount <= s[7:0];
        ovf = s[8];
        mSkip <= tick ? 2'd1 : 2'd2;
      end else if (tick) begin
        if (mSkip != 0) mSkip <= mSkip - 2'd1;
        else begin
          mCount <= mCount + 8'd1;
          ovf = (mCount == 8'hFF);
        end
      end
      if (ovf) mFlag <= 1'b1;
      else if (irqClr) mFlag <= 1'b0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      check({curTag, " count"}, count, mCount);
      check({curTag, " irq"}, irq, mFlag);
    end
  end

  task automatic waitIrq(output int at);
    at = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) begin at = cyc; break; end
    end
  endtask

  task automatic pulseClr();
    irqClr = 1'b1;
    @(negedge clk);
    irqClr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1 reset count", count, 0);
    check("R1 reset irq", irq, 0);
    rstN = 1'b1;                       // first rising edge after this is edge 1

    // R2 prescaled counting, R3 uncorrected period
    curTag = "R2";
    cmpOn = 1'b1;
    repeat (9) @(negedge clk);
    check("R2 count after 9 edges", count, 2);
    waitIrq(t0);
    check("R3 first wrap edge", t0, 1024);
    check("R3 count at wrap", count, 0);
    // R4 sticky flag
    curTag = "R4";
    repeat (20) @(negedge clk);
    check("R4 flag held", irq, 1);
    pulseClr();
    check("R4 flag cleared", irq, 0);
    curTag = "R3";
    waitIrq(t1);
    check("R3 second wrap spacing", t1 - t0, 1024);
    pulseClr();

    // R5/R6 directed add right after an increment edge
    curTag = "R6";
    while (count != 8'd10) @(negedge clk);
    addVal = 8'd5; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check("R5 add applied", count, 15);
    repeat (10) @(negedge clk);
    check("R6 increments skipped", count, 15);
    repeat (8) @(negedge clk);
    check("R6 counting resumed", count > 15, 1);

    // R7 add that carries out
    curTag = "R7";
    while (count != 8'hF0) @(negedge clk);
    addVal = 8'h20; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check("R7 carry sets irq", irq, 1);
    check("R7 wrapped sum", count, 8'h10);
    pulseClr();

    // R8 corrected period with add 8 at random delays
    curTag = "R8";
    waitIrq(t0);
    for (int k = 0; k < 12; k++) begin
      int d;
      d = (k == 0) ? 0 : ((k == 1) ? 3 : int'($urandom_range(0, 900)));
      pulseClr();
      repeat (d) @(negedge clk);
      addVal = 8'd8; wrEn = 1'b1;
      @(negedge clk);
      wrEn = 1'b0;
      waitIrq(t1);
      check("R8 corrected period", t1 - t0, 1000);
      t0 = t1;
    end
    pulseClr();

    // Random mix compared against the model (R5, R6, R7, R4)
    curTag = "R5";
    for (int i = 0; i < 4000; i++) begin
      wrEn   = ($urandom_range(0, 15) == 0);
      addVal = 8'($urandom_range(0, 255));
      irqClr = ($urandom_range(0, 7) == 0);
      @(negedge clk);
    end
    wrEn = 1'b0; irqClr = 1'b0;
    @(negedge clk);
    cmpOn = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule